// File: doc/BRIEF.md
# Clock-Jitter Random Bit Sampler with APB Read Port

This block is the digital back end of a true random number generator. The randomness comes from two clocks whose frequencies have a fixed rational ratio. A free-running reference square wave is sampled on the rising edges of a separate sampling clock. The sample passes through two flip-flops in series, so the first stage may go metastable without affecting the logic that follows. Over a fixed window of `WINDOW` sampling edges, the synchronized samples are reduced to one raw bit by taking their parity. Successive raw bits are shifted into a 32-bit word, most significant bit first.

Each finished word is handed from the sampling clock domain to the APB clock domain by a toggle handshake. In the APB domain a ready flag is raised. A processor polls a status register and reads the word from a data register. If a word finishes while the previous one is still unread, the unread word is kept, the new one is dropped, and an overrun flag records the loss. The clock sources themselves are not part of the block. The default window of 2401 sampling edges gives about 40.8 kbit/s from a 98 MHz sampling clock.

Top module: `trng_jitter_apb`

## Requirements
- R1: The reference input passes through two flip-flops clocked by the sampling clock. The sample captured at sampling edge e is the one that enters the parity at edge e+2.
- R2: Counting from the first sampling edge after reset, every run of `WINDOW` edges forms one window. The raw bit of a window is the XOR of the synchronized samples that enter during that window, and the parity starts from zero in each window.
- R3: Raw bits are packed most significant bit first. The first bit of a word ends up in bit 31 and the 32nd bit in bit 0.
- R4: When a 32-bit word is complete, it appears in the APB domain with status bit 0 (ready) set to 1.
- R5: An APB read at offset 0x0 returns the held word, and that access clears the ready flag.
- R6: If a word completes while ready is 1 and no data read happens in that cycle, status bit 1 (overrun) is set. The unread word stays in the data register and the new word is discarded.
- R7: An APB read at offset 0x4 returns {30'b0, overrun, ready} and clears the overrun flag. Ready is left unchanged.
- R8: Reads at any offset other than 0x0 and 0x4 return 0. APB writes change no state. pready is always 1 and pslverr is always 0.
- R9: After reset, the data register reads 0 and the status register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| samp_clk | input | 1 | Sampling clock |
| samp_rst_n | input | 1 | Active-low asynchronous reset, sampling domain |
| ref_in | input | 1 | Jittery reference clock to be sampled |
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low asynchronous reset, APB domain |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe (writes are ignored) |
| paddr | input | ADDR_W | APB byte address |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |

## Verification
The bench drives ideal and jittered reference clocks whose edges never coincide with sampling edges. It models the two-edge latency and the window parity on its own. A design that got the latency or the window boundary wrong would give words that differ from the model. A stuck-high reference with an odd window must give all ones, and a stuck-low reference must give all zeros. A design that forgot to clear the parity between windows would break these patterns. The bench lets two words pile up, to check the following:
- The older word survives an overrun; a design that overwrites it returns the wrong value.
- APB writes leave the flags unchanged.
- A status read clears only the overrun flag; a design that also dropped ready would report status 0 where 1 is expected.

// File: rtl/trng_pkg.sv
`timescale 1ps/1ps
package trng_pkg;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              ready;
        logic              ovr;
        logic [2:0]        tsync;
    } apb_st_t;
endpackage

// File: rtl/trng_sync2.sv
`timescale 1ps/1ps
module trng_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    typedef struct packed {
        logic s1;
        logic s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign d_out = st_q.s2;
endmodule

// File: rtl/trng_window.sv
`timescale 1ps/1ps
module trng_window #(
    parameter int WINDOW = 2401
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp,
    output logic bit_vld,
    output logic bit_val
);
    localparam int CW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
    localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          acc;
        logic          vld;
        logic          bitv;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic par;
        st_d     = st_q;
        par      = st_q.acc ^ samp;
        st_d.vld = 1'b0;
        if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.acc  = 1'b0;
            st_d.bitv = par;
            st_d.vld  = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.acc = par;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_vld = st_q.vld;
    assign bit_val = st_q.bitv;

    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
    a_r2_one_bit_per_window: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> !bit_vld);
endmodule

// File: rtl/trng_packer.sv
`timescale 1ps/1ps
module trng_packer
    import trng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_val,
    output logic [WORD_W-1:0] word,
    output logic              tog
);
    localparam int IW = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [IW-1:0]     idx;
        logic [WORD_W-1:0] word;
        logic              tog;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [WORD_W-1:0] nsh;
        st_d = st_q;
        nsh  = {st_q.sh[WORD_W-2:0], bit_val};
        if (bit_vld) begin
            st_d.sh = nsh;
            if (st_q.idx == IW'(WORD_W - 1)) begin
                st_d.idx  = '0;
                st_d.word = nsh;
                st_d.tog  = ~st_q.tog;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.word;
    assign tog  = st_q.tog;

    a_r3_toggle_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && st_q.idx == IW'(WORD_W - 1)) |=> (tog != $past(tog)));
    a_r3_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(word));
endmodule

// File: rtl/trng_apb_regs.sv
`timescale 1ps/1ps
module trng_apb_regs
    import trng_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] xfer_word,
    input  logic              xfer_tog,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic [WORD_W-1:0] prdata
);
    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4);

    apb_st_t st_d, st_q;
    logic    arrive, rd_data, rd_stat;

    assign arrive  = st_q.tsync[1] ^ st_q.tsync[2];
    assign rd_data = psel && penable && !pwrite && (paddr == OFS_DATA);
    assign rd_stat = psel && penable && !pwrite && (paddr == OFS_STAT);

    always_comb begin
        st_d       = st_q;
        st_d.tsync = {st_q.tsync[1:0], xfer_tog};
        if (arrive && (!st_q.ready || rd_data)) begin
            st_d.data  = xfer_word;
            st_d.ready = 1'b1;
        end else if (rd_data) begin
            st_d.ready = 1'b0;
        end
        if (arrive && st_q.ready && !rd_data) st_d.ovr = 1'b1;
        else if (rd_stat)                     st_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if (paddr == OFS_DATA)      prdata = st_q.data;
            else if (paddr == OFS_STAT) prdata = {{(WORD_W-2){1'b0}}, st_q.ovr, st_q.ready};
        end
    end

    a_r4_ready_on_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        arrive |=> st_q.ready);
    a_r5_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !arrive) |=> !st_q.ready);
    a_r6_overrun_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive && st_q.ready && !rd_data) |=> (st_q.ovr && $stable(st_q.data)));
    a_r7_status_clears_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !(arrive && st_q.ready && !rd_data)) |=> !st_q.ovr);
    a_r8_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && pwrite && !arrive) |=> ($stable(st_q.data) && $stable(st_q.ready)));
endmodule

// File: rtl/trng_jitter_apb.sv
`timescale 1ps/1ps
module trng_jitter_apb
    import trng_pkg::*;
#(
    parameter int WINDOW = 2401,
    parameter int ADDR_W = 4
) (
    input  logic              samp_clk,
    input  logic              samp_rst_n,
    input  logic              ref_in,
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr
);
    logic              samp_s, bit_vld, bit_val, xfer_tog;
    logic [WORD_W-1:0] xfer_word;

    trng_sync2 u_sync (
        .clk(samp_clk), .rst_n(samp_rst_n), .d_in(ref_in), .d_out(samp_s)
    );

    trng_window #(.WINDOW(WINDOW)) u_win (
        .clk(samp_clk), .rst_n(samp_rst_n), .samp(samp_s),
        .bit_vld(bit_vld), .bit_val(bit_val)
    );

    trng_packer u_pack (
        .clk(samp_clk), .rst_n(samp_rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
        .word(xfer_word), .tog(xfer_tog)
    );

    trng_apb_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(pclk), .rst_n(presetn), .xfer_word(xfer_word), .xfer_tog(xfer_tog),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .prdata(prdata)
    );

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
endmodule

// File: tb/trng_jitter_apb_tb.sv
`timescale 1ps/1ps
module trng_jitter_apb_tb;
    localparam int W = 7;

    typedef struct packed {
        logic [31:0] half;
        logic [31:0] jit;
        logic        stuck;
        logic        sval;
        logic        chk;
        logic [31:0] cval;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{32'd0,    32'd0,  1'b1, 1'b0, 1'b1, 32'h0000_0000},
        '{32'd0,    32'd0,  1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF},
        '{32'd5110, 32'd0,  1'b0, 1'b0, 1'b0, 32'h0},
        '{32'd5190, 32'd20, 1'b0, 1'b0, 1'b0, 32'h0},
        '{32'd4970, 32'd30, 1'b0, 1'b0, 1'b0, 32'h0}
    };

    logic       samp_clk = 0, pclk = 0, samp_rst_n = 0, presetn = 0, ref_r = 0;
    logic       psel = 0, penable = 0, pwrite = 0;
    logic [3:0] paddr = 0;
    logic [31:0] prdata;
    logic       pready, pslverr;

    int total = 0, bad = 0;
    bit done = 0;
    int cur_half = 0, cur_jit = 0;
    bit cur_stuck = 1, cur_sval = 0;

    trng_jitter_apb #(.WINDOW(W), .ADDR_W(4)) u_dut (
        .samp_clk(samp_clk), .samp_rst_n(samp_rst_n), .ref_in(ref_r),
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .prdata(prdata),
        .pready(pready), .pslverr(pslverr)
    );

    always #2000 pclk = ~pclk;
    always #5000 samp_clk = ~samp_clk;

    // reference generator: edges at times ending in 3 ps, sampling edges at multiples of 10 ps
    initial begin
        int k;
        k = 0;
        #3;
        forever begin
            if (cur_stuck) begin
                ref_r = cur_sval;
                #10;
            end else begin
                ref_r = ~ref_r;
                #(cur_half + ((k % 3) - 1) * cur_jit);
                k++;
            end
        end
    end

    // independent model: two-edge latency, window parity, MSB-first packing
    logic [31:0] exp_q [$];
    logic h1 = 0, h2 = 0, macc = 0;
    logic [31:0] mword = 0;
    int mpos = 0, mnb = 0;
    always @(posedge samp_clk) begin
        if (samp_rst_n) begin
            logic c;
            c    = h2;
            h2   = h1;
            h1   = ref_r;
            macc = macc ^ c;
            if (mpos == W - 1) begin
                mword = {mword[30:0], macc};
                macc  = 0;
                mnb++;
                if (mnb == 32) begin
                    exp_q.push_back(mword);
                    mnb = 0;
                end
                mpos = 0;
            end else begin
                mpos++;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic apb_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk);
        penable = 1;
        #1;
        d = prdata;
        check("R8 pready", {31'b0, pready}, 32'd1);
        check("R8 pslverr", {31'b0, pslverr}, 32'd0);
        @(negedge pclk);
        psel = 0; penable = 0;
    endtask

    task automatic apb_write(input logic [3:0] a);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 1; paddr = a;
        @(negedge pclk);
        penable = 1;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic wait_ready();
        logic [31:0] s;
        s = 0;
        while (s[0] !== 1'b1) apb_read(4'h4, s);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge pclk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d, e;
        repeat (4) @(negedge pclk);
        presetn = 1;
        @(negedge samp_clk);
        samp_rst_n = 1;

        // R9 reset state
        apb_read(4'h0, d); check("R9 data after reset", d, 32'h0);
        apb_read(4'h4, d); check("R9 status after reset", d, 32'h0);
        // R8 unmapped offset
        apb_read(4'h8, d); check("R8 unmapped read", d, 32'h0);

        // table-driven run: R1 R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            cur_half  = int'(VECS[v].half);
            cur_jit   = int'(VECS[v].jit);
            cur_sval  = VECS[v].sval;
            cur_stuck = VECS[v].stuck;
            for (int w = 0; w < 3; w++) begin
                wait_ready();
                apb_read(4'h0, d);
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD_BEEF;
                check("R1 R2 R3 R4 word vs model", d, e);
                if (VECS[v].chk && w == 2) check("R2 stuck parity", d, VECS[v].cval);
                apb_read(4'h4, d);
                check("R5 ready cleared by data read", d & 32'h1, 32'h0);
            end
        end

        // overrun: let two words pile up
        while (exp_q.size() < 2) @(negedge pclk);
        repeat (20) @(negedge pclk);
        apb_write(4'h4);
        apb_write(4'h0);
        apb_read(4'h4, d); check("R6 R8 overrun set, writes ignored", d, 32'h3);
        apb_read(4'h4, d); check("R7 status read clears overrun only", d, 32'h1);
        apb_read(4'h0, d); check("R6 older word kept", d, exp_q[0]);
        void'(exp_q.pop_front());
        void'(exp_q.pop_front());
        apb_read(4'h4, d); check("R5 ready cleared after overrun read", d, 32'h0);

        if (!done) begin
            done = 1;
            summary();
            $finish;
        end
    end
endmodule